// File: doc/BRIEF.md
# Input Capture Unit with Coherent Two-Byte Readout

This block timestamps falling transitions on an external pin for a microcontroller with an 8-bit data bus. A 16-bit free-running count advances once every four bus clocks. The pin is brought into the clock domain through a synchronizer, and a falling-edge detector produces a single-cycle capture strobe. On that strobe the unit stores a timestamp and sets a capture flag. An interrupt request is raised when the enable input is high.

Software reads the 16-bit timestamp as two byte registers, upper byte first. A read of the upper byte starts a hold. Captures that arrive during the hold are discarded, so the lower byte read next always belongs to the same timestamp. The hold ends when the lower byte is read. The timestamp is one count past the counter value that was present when the pin fell, which makes up for the synchronizer delay. Reset does not change the stored timestamp.

The design is built from two state machines. The hold machine has the states LK_OPEN and LK_HELD. It goes from LK_OPEN to LK_HELD on an upper-byte read, and from LK_HELD to LK_OPEN on a lower-byte read. The flag machine has the states FL_CLEAR, FL_SET and FL_ARMED. It goes from FL_CLEAR to FL_SET on an accepted capture, and from FL_SET to FL_ARMED on a status read. It goes from FL_ARMED to FL_CLEAR on a lower-byte read, and from FL_ARMED back to FL_SET on an accepted capture, which wins over the clear.

Top module: `icap_coherent`

## Requirements
- R1: After reset `free_count` is 0. It advances by exactly one on every fourth rising clock edge, so it first reads 1 after the fourth edge that follows reset release.
- R2: A high-to-low change on `cap_pin` stores a timestamp equal to one plus the `free_count` value present when the pin changed. The timestamp, the flag and `cap_irq` become visible after the third rising edge that follows the change, and not after the second.
- R3: A low-to-high change on `cap_pin` stores nothing and does not set the flag.
- R4: Every accepted capture overwrites the timestamp, whether the flag is already set or not. The register always holds the newest accepted capture.
- R5: An accepted capture sets the flag. `cap_irq` is high exactly when the flag is set and `irq_en` is high.
- R6: A read of address 2 returns timestamp bits 15:8 and starts a hold. A falling edge whose capture would land during the hold is discarded. The timestamp keeps its old value and the flag does not change.
- R7: A read of address 3 returns timestamp bits 7:0 and ends the hold. A read of address 3 with no hold active does not block later captures.
- R8: The flag clears only when a status read made while the flag is set is followed by a read of address 3. A read of address 3 with no prior status read leaves the flag set.
- R9: If a capture is accepted in the same cycle as the clearing read of address 3, the flag stays set.
- R10: Reset clears the flag, `cap_irq` and the hold, and zeroes the count. The stored timestamp keeps its value across reset.
- R11: A read of address 0 returns the flag in bit 7 and zeros in all other bits. A read of address 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | External capture pin, asynchronous |
| irq_en | input | 1 | Capture interrupt enable |
| bus_addr | input | 2 | Register address: 0 status, 2 upper byte, 3 lower byte |
| bus_rd | input | 1 | Read strobe; side effects apply at the rising edge |
| bus_rdata | output | 8 | Combinational read data |
| cap_irq | output | 1 | Interrupt request |
| free_count | output | 16 | Free-running count |

## Verification
A capture result is due at the third rising edge after the pin falls: two synchronizer stages plus the capture register. The bench drives the pin on a falling clock edge and takes `free_count` at that moment as the base for the expected value. It checks that `cap_irq` is still low after two edges and high after three. Read side effects take hold at the rising edge inside a read cycle, while read data is taken combinationally 1 ns after the strobe is driven. The test where capture and clear coincide therefore places the lower-byte read in the cycle that ends at that third edge. Count checks are taken at fixed distances of four and three edges from a known phase.

// File: rtl/icap_pkg.sv
package icap_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int FLAG_BIT = 7;

    localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 2'd2;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 2'd3;

    typedef enum logic [0:0] {
        LK_OPEN,
        LK_HELD
    } lock_state_t;

    typedef enum logic [1:0] {
        FL_CLEAR,
        FL_SET,
        FL_ARMED
    } flag_state_t;
endpackage

// File: rtl/icap_timebase.sv
module icap_timebase #(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic advance;

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PS_W-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                div_q <= '0;
                else if (div_q == PS_LAST) div_q <= '0;
                else                       div_q <= div_q + 1'b1;
            end
            assign advance = (div_q == PS_LAST);
        end else begin : g_nodiv
            assign advance = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (advance) count <= count + 1'b1;
    end
endmodule

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [CNT_W-1:0] count,
    output logic             fall_stb,
    output logic [CNT_W-1:0] snap
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [CNT_W-1:0]       snap_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '1;
            prev_q    <= 1'b1;
            snap_q[0] <= '0;
        end else begin
            sync_q[0] <= pin;
            prev_q    <= sync_q[SYNC_STAGES-1];
            snap_q[0] <= count;
        end
    end

    genvar gi;
    generate
        for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[gi] <= 1'b1;
                    snap_q[gi] <= '0;
                end else begin
                    sync_q[gi] <= sync_q[gi-1];
                    snap_q[gi] <= snap_q[gi-1];
                end
            end
        end
    endgenerate

    assign fall_stb = prev_q & ~sync_q[SYNC_STAGES-1];
    assign snap     = snap_q[SYNC_STAGES-1];
endmodule

// File: rtl/icap_read_lock.sv
module icap_read_lock
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hi,
    input  logic rd_lo,
    input  logic strobe,
    output logic locked,
    output logic take
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (rd_hi) state_d = LK_HELD;
            LK_HELD: if (rd_lo) state_d = LK_OPEN;
            default: state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        locked = 1'b0;
        take   = 1'b0;
        unique case (state_q)
            LK_OPEN: take = strobe & ~rd_hi;
            LK_HELD: begin
                locked = 1'b1;
                take   = strobe & rd_lo;
            end
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_flag_ctrl.sv
module icap_flag_ctrl
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic rd_status,
    input  logic rd_lo,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (take) state_d = FL_SET;
            FL_SET:   if (rd_status && !take) state_d = FL_ARMED;
            FL_ARMED: begin
                if (take)       state_d = FL_SET;
                else if (rd_lo) state_d = FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FL_CLEAR: flag = 1'b0;
            FL_SET:   flag = 1'b1;
            FL_ARMED: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_coherent.sv
module icap_coherent
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              cap_irq,
    output logic [CNT_W-1:0]  free_count
);
    logic             fall_stb;
    logic [CNT_W-1:0] snap;
    logic             rd_status, rd_hi, rd_lo;
    logic             locked, cap_take, flag;
    logic [CNT_W-1:0] cap_q;

    assign rd_status = bus_rd && (bus_addr == A_STATUS);
    assign rd_hi     = bus_rd && (bus_addr == A_CAP_HI);
    assign rd_lo     = bus_rd && (bus_addr == A_CAP_LO);

    icap_timebase #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_tb (
        .clk(clk), .rst_n(rst_n), .count(free_count)
    );

    icap_sync_edge #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .count(free_count),
        .fall_stb(fall_stb), .snap(snap)
    );

    icap_read_lock u_lock (
        .clk(clk), .rst_n(rst_n), .rd_hi(rd_hi), .rd_lo(rd_lo),
        .strobe(fall_stb), .locked(locked), .take(cap_take)
    );

    icap_flag_ctrl u_flag (
        .clk(clk), .rst_n(rst_n), .take(cap_take), .rd_status(rd_status),
        .rd_lo(rd_lo), .flag(flag)
    );

    // Timestamp register: deliberately outside reset.
    always_ff @(posedge clk) begin
        if (cap_take) cap_q <= snap + 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_STATUS: bus_rdata[FLAG_BIT] = flag;
                A_CAP_HI: bus_rdata = cap_q[CNT_W-1 -: BYTE_W];
                A_CAP_LO: bus_rdata = cap_q[BYTE_W-1:0];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign cap_irq = flag & irq_en;
endmodule

// File: rtl/icap_coherent_chk.sv
module icap_coherent_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fall_stb,
    input logic             cap_take,
    input logic             locked,
    input logic             rd_lo,
    input logic             flag,
    input logic             irq_en,
    input logic             cap_irq,
    input logic [CNT_W-1:0] cap_q,
    input logic [CNT_W-1:0] free_count
);
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_count != $past(free_count)) |-> (free_count == $past(free_count) + 1'b1));

    // R2
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);

    // R3
    no_take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_take |=> $stable(cap_q));

    // R5
    take_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |=> flag);

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> (irq_en && flag));

    // R6
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rd_lo) |=> $stable(cap_q));
endmodule

bind icap_coherent icap_coherent_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .cap_take(cap_take),
    .locked(locked), .rd_lo(rd_lo), .flag(flag), .irq_en(irq_en),
    .cap_irq(cap_irq), .cap_q(cap_q), .free_count(free_count)
);

// File: tb/icap_coherent_tb_top.sv
module icap_coherent_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 6;
    localparam int unsigned GAP_TAB [NVEC] = '{0, 1, 2, 3, 5, 9};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b1;
    logic        irq_en = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cap_irq;
    logic [15:0] free_count;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icap_coherent dut_i (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .irq_en(irq_en),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cap_irq(cap_irq), .free_count(free_count)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_cap(output logic [15:0] v);
        logic [7:0] h, l;
        do_read(2'd2, h);
        do_read(2'd3, l);
        v = {h, l};
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        do_read(2'd0, d);
        do_read(2'd3, d);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] exp, got, base, old;
        logic [7:0]  d;

        wait_n(3);
        rst_n = 1'b1;
        // R10 reset state; R1 first step after the fourth edge
        #1;
        check("R10 count", free_count, 16'd0);
        check("R10 irq", {15'd0, cap_irq}, 16'd0);
        wait_n(3);
        check("R1 before 4th edge", free_count, 16'd0);
        wait_n(1);
        check("R1 at 4th edge", free_count, 16'd1);
        base = free_count;
        wait_n(8);
        check("R1 two steps", free_count, base + 16'd2);
        do_read(2'd0, d);
        check("R11 status clear", {8'd0, d}, 16'd0);
        do_read(2'd1, d);
        check("R11 unmapped", {8'd0, d}, 16'd0);

        // R2 table walk across prescaler phases
        for (int i = 0; i < NVEC; i++) begin
            clear_flag();
            wait_n(GAP_TAB[i]);
            cap_pin = 1'b0;
            exp = free_count + 16'd1;
            wait_n(2);
            check("R2 not before third edge", {15'd0, cap_irq}, 16'd0);
            wait_n(1);
            check("R2 irq at third edge", {15'd0, cap_irq}, 16'd1);
            read_cap(got);
            check("R2 timestamp", got, exp);
            cap_pin = 1'b1;
            wait_n(4);
        end

        // R3 rising edge ignored
        clear_flag();
        read_cap(old);
        cap_pin = 1'b0; wait_n(4); clear_flag(); read_cap(old);
        cap_pin = 1'b1; wait_n(5);
        do_read(2'd0, d);
        check("R3 no flag on rise", {8'd0, d}, 16'd0);
        read_cap(got);
        check("R3 value kept on rise", got, old);

        // R4 overwrite while flag set
        cap_pin = 1'b0; wait_n(4); cap_pin = 1'b1; wait_n(6);
        cap_pin = 1'b0; exp = free_count + 16'd1; wait_n(4); cap_pin = 1'b1; wait_n(3);
        read_cap(got);
        check("R4 newest kept", got, exp);

        // R5 irq gating and status bit 7
        irq_en = 1'b0; #1;
        check("R5 irq masked", {15'd0, cap_irq}, 16'd0);
        irq_en = 1'b1; #1;
        check("R5 irq enabled", {15'd0, cap_irq}, 16'd1);

        // R8 low read alone keeps flag
        wait_n(1);
        do_read(2'd3, d);
        check("R8 flag kept", {15'd0, cap_irq}, 16'd1);
        do_read(2'd0, d);
        check("R11 status bit7", {8'd0, d}, 16'h0080);
        do_read(2'd3, d);
        check("R8 flag cleared", {15'd0, cap_irq}, 16'd0);

        // R6 hold drops capture; R7 low read releases
        read_cap(old);
        do_read(2'd2, d);
        cap_pin = 1'b0; wait_n(5); cap_pin = 1'b1;
        check("R6 no flag while held", {15'd0, cap_irq}, 16'd0);
        read_cap(got);
        check("R6 value kept while held", got, old);
        wait_n(4);
        do_read(2'd3, d);
        cap_pin = 1'b0; exp = free_count + 16'd1; wait_n(3); cap_pin = 1'b1;
        read_cap(got);
        check("R7 lone low read does not hold", got, exp);
        wait_n(4);

        // R9 capture coincides with clearing read
        do_read(2'd0, d);
        cap_pin = 1'b0; exp = free_count + 16'd1;
        wait_n(2);
        do_read(2'd3, d);
        check("R9 flag stays set", {15'd0, cap_irq}, 16'd1);
        cap_pin = 1'b1; wait_n(4);
        read_cap(got);
        check("R9 timestamp", got, exp);

        // R10 timestamp survives reset
        rst_n = 1'b0; wait_n(3); rst_n = 1'b1; #1;
        check("R10 count reset", free_count, 16'd0);
        check("R10 irq reset", {15'd0, cap_irq}, 16'd0);
        wait_n(1);
        read_cap(got);
        check("R10 timestamp kept", got, exp);

        done = 1'b1;
        finish_run();
    end
endmodule